// File: doc/BRIEF.md
# Serial Keystroke Echo Controller

This block is a serial bridge that works in both directions. It watches an asynchronous serial receive line and keeps only the byte that arrived last. When an operator presses a push button, it sends that byte back out on the serial transmit line. After reset the kept byte is the ASCII letter 'h', so the first press on a quiet line echoes that letter.

Inside, four parts work together. A receiver turns line frames into bytes. A holding register keeps the newest good byte. A button conditioner turns a bouncing contact into one clean send request. A transmitter serialises the held byte. The parts pass data through request/acknowledge pairs. The transmit request stays raised until the transmitter reports the frame finished, and the conditioner ignores new presses while that exchange is open.

The bit period and the debounce interval are counts of clock cycles. With a 100 MHz clock, 10417 cycles per bit gives 9600 baud, and 1,000,000 cycles gives a debounce of about 10 ms.

Top module: `uart_echo`

## Requirements
- R1: A transmitted frame is one low start bit, then the eight data bits with bit 0 first, then one high stop bit. Each bit lasts exactly CLK_PER_BIT cycles, and the line stays high whenever no frame is being sent.
- R2: After reset the transmit line is high and the held byte is 0x68, so a press before any reception sends 0x68.
- R3: Every correctly framed received byte replaces the held byte. A press sends only the newest byte, however many bytes came in since the last press.
- R4: A received frame whose stop bit samples low is dropped and leaves the held byte unchanged.
- R5: Each accepted press produces exactly one frame, carrying the byte held when the frame begins.
- R6: A press that completes while a send request is open, or while the transmitter still reports the previous frame done, is ignored and produces no frame.
- R7: The button must stay at its new level for DEB_CYCLES consecutive cycles after synchronisation before it counts. Shorter pulses and contact bounce produce no frame, and a bouncing press that then settles gives exactly one frame.
- R8: The receiver samples each bit in the middle of its period, timed from the falling edge of the start bit. A low pulse shorter than half a bit is treated as noise and does not start a frame.
- R9: The send request stays high until the transmitter raises done. Done rises only while the request is high, and the request drops in the cycle after done is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Asynchronous serial receive line, idle high |
| btn_i | input | 1 | Raw push-button level, high when pressed |
| tx_o | output | 1 | Serial transmit line, registered, idle high |

## Verification
On every cycle the assertions check the handshake between the button conditioner and the transmitter: the request is held until done, done needs an open request, the request is released after done, and a new request is raised only when the transmitter is idle. They also check that the held byte changes only on a receiver hand-off, that it reloads 0x68 after reset, that the line is high while the transmitter is idle, and that the byte being sent cannot change partway through a frame. Only the bench scenarios can show that a press sends the newest good byte, that frames with a bad stop bit and short start glitches are dropped, and that short or bouncing button pulses give the right number of frames. For this the bench compares the transmit line, one cycle at a time, against the frame its own model predicts.

// File: rtl/uart_echo_pkg.sv
package uart_echo_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_DONE,
    RX_BREAK
  } rx_state_t;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_START,
    TX_DATA,
    TX_STOP,
    TX_FIN
  } tx_state_t;

endpackage

// File: rtl/uart_echo_sync.sv
module uart_echo_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] st;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) st <= RST_VAL;
        else     st <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) st <= {STAGES{RST_VAL}};
        else     st <= {st[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = st[STAGES-1];

endmodule

// File: rtl/uart_echo_rx.sv
module uart_echo_rx
  import uart_echo_pkg::*;
#(
  parameter int CLK_PER_BIT = 10417,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_i,
  input  logic              ack,
  output logic              rdy,
  output logic [DATA_W-1:0] data
);

  localparam int CW   = $clog2(CLK_PER_BIT + 1);
  localparam int IW   = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int HALF = CLK_PER_BIT / 2;

  logic              line;
  rx_state_t         st;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     idx;
  logic [DATA_W-1:0] sh;

  uart_echo_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (rx_i),
    .q   (line)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= RX_IDLE;
      cnt <= '0;
      idx <= '0;
      sh  <= '0;
      rdy <= 1'b0;
    end else begin
      case (st)
        RX_IDLE: begin
          cnt <= '0;
          idx <= '0;
          if (!line) st <= RX_START;
        end
        RX_START: begin
          if (cnt == CW'(HALF - 1)) begin
            cnt <= '0;
            st  <= line ? RX_IDLE : RX_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt == CW'(CLK_PER_BIT - 1)) begin
            cnt <= '0;
            sh  <= {line, sh[DATA_W-1:1]};
            if (idx == IW'(DATA_W - 1)) st <= RX_STOP;
            else                        idx <= idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt == CW'(CLK_PER_BIT - 1)) begin
            cnt <= '0;
            if (line) begin
              rdy <= 1'b1;
              st  <= RX_DONE;
            end else begin
              st <= RX_BREAK;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_DONE: begin
          if (ack) begin
            rdy <= 1'b0;
            st  <= RX_IDLE;
          end
        end
        RX_BREAK: begin
          if (line) st <= RX_IDLE;
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  assign data = sh;

endmodule

// File: rtl/uart_echo_tx.sv
module uart_echo_tx
  import uart_echo_pkg::*;
#(
  parameter int CLK_PER_BIT = 10417,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [DATA_W-1:0] din,
  output logic              line,
  output logic              done,
  output logic              busy,
  output logic [DATA_W-1:0] cur
);

  localparam int CW = $clog2(CLK_PER_BIT + 1);
  localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  tx_state_t     st;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic          bit_end;

  assign bit_end = (cnt == CW'(CLK_PER_BIT - 1));
  assign busy    = (st != TX_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= TX_IDLE;
      cnt  <= '0;
      idx  <= '0;
      cur  <= '0;
      line <= 1'b1;
      done <= 1'b0;
    end else begin
      case (st)
        TX_IDLE: begin
          line <= 1'b1;
          cnt  <= '0;
          idx  <= '0;
          if (req) begin
            cur  <= din;
            line <= 1'b0;
            st   <= TX_START;
          end
        end
        TX_START: begin
          if (bit_end) begin
            cnt  <= '0;
            line <= cur[0];
            st   <= TX_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        TX_DATA: begin
          if (bit_end) begin
            cnt <= '0;
            if (idx == IW'(DATA_W - 1)) begin
              line <= 1'b1;
              st   <= TX_STOP;
            end else begin
              idx  <= idx + 1'b1;
              line <= cur[idx + 1'b1];
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        TX_STOP: begin
          if (bit_end) begin
            cnt  <= '0;
            done <= 1'b1;
            st   <= TX_FIN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        TX_FIN: begin
          if (!req) begin
            done <= 1'b0;
            st   <= TX_IDLE;
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_echo_btn.sv
module uart_echo_btn #(
  parameter int DEB_CYCLES  = 1000000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_i,
  input  logic done,
  output logic req
);

  localparam int CW = $clog2(DEB_CYCLES + 1);

  logic          b_sync;
  logic          level;
  logic [CW-1:0] cnt;
  logic          settle;
  logic          rise;

  uart_echo_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (btn_i),
    .q   (b_sync)
  );

  assign settle = (b_sync != level) && (cnt == CW'(DEB_CYCLES - 1));
  assign rise   = settle && b_sync;

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= 1'b0;
      cnt   <= '0;
    end else if (b_sync == level) begin
      cnt <= '0;
    end else if (settle) begin
      level <= b_sync;
      cnt   <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                          req <= 1'b0;
    else if (req && done)             req <= 1'b0;
    else if (rise && !req && !done)   req <= 1'b1;
  end

endmodule

// File: rtl/uart_echo_hold.sv
module uart_echo_hold #(
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] RESET_BYTE = 8'h68
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rdy,
  input  logic [DATA_W-1:0] din,
  output logic              ack,
  output logic [DATA_W-1:0] dout
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= RESET_BYTE;
      ack  <= 1'b0;
    end else if (rdy && !ack) begin
      dout <= din;
      ack  <= 1'b1;
    end else if (!rdy) begin
      ack <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_echo.sv
module uart_echo #(
  parameter int                CLK_PER_BIT = 10417,
  parameter int                DEB_CYCLES  = 1000000,
  parameter int                DATA_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] RESET_BYTE  = 8'h68
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_i,
  input  logic btn_i,
  output logic tx_o
);

  logic              rx_rdy;
  logic              rx_ack;
  logic [DATA_W-1:0] rx_data;
  logic [DATA_W-1:0] held;
  logic              tx_req;
  logic              tx_done;
  logic              tx_busy;
  logic [DATA_W-1:0] tx_cur;

  uart_echo_rx #(
    .CLK_PER_BIT (CLK_PER_BIT),
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_rx (
    .clk  (clk),
    .rst  (rst),
    .rx_i (rx_i),
    .ack  (rx_ack),
    .rdy  (rx_rdy),
    .data (rx_data)
  );

  uart_echo_hold #(
    .DATA_W     (DATA_W),
    .RESET_BYTE (RESET_BYTE)
  ) u_hold (
    .clk  (clk),
    .rst  (rst),
    .rdy  (rx_rdy),
    .din  (rx_data),
    .ack  (rx_ack),
    .dout (held)
  );

  uart_echo_btn #(
    .DEB_CYCLES  (DEB_CYCLES),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_btn (
    .clk   (clk),
    .rst   (rst),
    .btn_i (btn_i),
    .done  (tx_done),
    .req   (tx_req)
  );

  uart_echo_tx #(
    .CLK_PER_BIT (CLK_PER_BIT),
    .DATA_W      (DATA_W)
  ) u_tx (
    .clk  (clk),
    .rst  (rst),
    .req  (tx_req),
    .din  (held),
    .line (tx_o),
    .done (tx_done),
    .busy (tx_busy),
    .cur  (tx_cur)
  );

endmodule

// File: rtl/uart_echo_chk.sv
module uart_echo_chk #(
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] RESET_BYTE = 8'h68
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_o,
  input logic              tx_req,
  input logic              tx_done,
  input logic              tx_busy,
  input logic [DATA_W-1:0] tx_cur,
  input logic              rx_rdy,
  input logic              rx_ack,
  input logic [DATA_W-1:0] held
);

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> tx_o);

  assert_frame_byte_stable_R1: assert property (@(posedge clk) disable iff (rst)
    tx_busy |=> (!tx_busy || $stable(tx_cur)));

  assert_reset_byte_R2: assert property (@(posedge clk)
    rst |=> (held == RESET_BYTE));

  assert_hold_update_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(held) |-> $past(rx_rdy && !rx_ack));

  assert_req_only_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_req) |-> !tx_busy);

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (tx_req && !tx_done) |=> tx_req);

  assert_done_needs_req_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_done) |-> tx_req);

  assert_req_release_R9: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> !tx_req);

endmodule

bind uart_echo uart_echo_chk #(
  .DATA_W     (DATA_W),
  .RESET_BYTE (RESET_BYTE)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tx_o    (tx_o),
  .tx_req  (tx_req),
  .tx_done (tx_done),
  .tx_busy (tx_busy),
  .tx_cur  (tx_cur),
  .rx_rdy  (rx_rdy),
  .rx_ack  (rx_ack),
  .held    (held)
);

// File: tb/uart_echo_test.sv
module uart_echo_test;

  localparam int CPB = 16;
  localparam int DEB = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx  = 1'b1;
  logic btn = 1'b0;
  logic tx_o;

  always #4 clk = ~clk;

  uart_echo #(.CLK_PER_BIT(CPB), .DEB_CYCLES(DEB)) uut (
    .clk   (clk),
    .rst   (rst),
    .rx_i  (rx),
    .btn_i (btn),
    .tx_o  (tx_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int frames = 0;
  int exp_frames = 0;
  bit run_chk = 1'b0;
  bit finished = 1'b0;
  string ctx = "R2";

  logic [7:0] exp_q[$];
  logic [7:0] exp_hold = 8'h68;
  logic [7:0] fcur = 8'h00;
  int fpos = -1;
  int bidx = 0;
  logic exp_bit;

  task automatic chk_bit(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: tx line actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_int(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Reference model of the transmit line, compared on every clock (R1, R5)
  always @(negedge clk) begin
    if (run_chk && !finished) begin
      if (fpos < 0 && tx_o === 1'b0) begin
        if (exp_q.size() == 0) begin
          n_cmp++;
          n_bad++;
          $display("FAIL %s: unexpected frame start, tx actual 0 expected 1", ctx);
        end else begin
          fcur = exp_q.pop_front();
          fpos = 0;
          frames++;
        end
      end
      if (fpos >= 0) begin
        bidx = fpos / CPB;
        if (bidx == 0)      exp_bit = 1'b0;
        else if (bidx == 9) exp_bit = 1'b1;
        else                exp_bit = fcur[bidx-1];
        chk_bit((bidx == 0 || bidx == 9) ? "R1" : ctx, tx_o, exp_bit);
        fpos++;
        if (fpos == 10 * CPB) fpos = -1;
      end else if (tx_o !== 1'b0) begin
        chk_bit(ctx, tx_o, 1'b1);
      end
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(bit expect_frame);
    if (expect_frame) begin
      exp_q.push_back(exp_hold);
      exp_frames++;
    end
    btn = 1'b1;
    wait_cyc(DEB + 12);
    btn = 1'b0;
    wait_cyc(DEB + 12);
  endtask

  task automatic wait_idle();
    int g = 0;
    while ((exp_q.size() != 0 || fpos >= 0) && g < 3000) begin
      wait_cyc(1);
      g++;
    end
    n_cmp++;
    if (g >= 3000) begin
      n_bad++;
      $display("FAIL R5: expected frame never completed, pending actual %0d expected 0",
               exp_q.size());
      exp_q.delete();
      fpos = -1;
    end
    wait_cyc(4);
  endtask

  task automatic send_rx(logic [7:0] d, logic stop_bit);
    rx = 1'b0;
    wait_cyc(CPB);
    for (int i = 0; i < 8; i++) begin
      rx = d[i];
      wait_cyc(CPB);
    end
    rx = stop_bit;
    wait_cyc(CPB);
    rx = 1'b1;
    wait_cyc(2 * CPB);
  endtask

  initial begin
    wait_cyc(5);
    rst = 1'b0;
    @(negedge clk);
    run_chk = 1'b1;
    // R2: reset leaves the line high, first press sends 0x68
    chk_bit("R2", tx_o, 1'b1);
    ctx = "R2";
    press(1'b1);
    wait_idle();

    // R3: one byte, then several bytes with only the newest echoed
    ctx = "R3";
    send_rx(8'h89, 1'b1); exp_hold = 8'h89;
    press(1'b1);
    wait_idle();
    send_rx(8'h2A, 1'b1);
    send_rx(8'h79, 1'b1);
    send_rx(8'h2D, 1'b1); exp_hold = 8'h2D;
    press(1'b1);
    wait_idle();

    // R1: extreme data patterns
    ctx = "R1";
    send_rx(8'h00, 1'b1); exp_hold = 8'h00;
    press(1'b1);
    wait_idle();
    send_rx(8'hFF, 1'b1); exp_hold = 8'hFF;
    press(1'b1);
    wait_idle();
    send_rx(8'h2D, 1'b1); exp_hold = 8'h2D;

    // R4: low stop bit drops the frame
    ctx = "R4";
    send_rx(8'hC3, 1'b0);
    press(1'b1);
    wait_idle();

    // R8: short low glitch on rx is noise; a good frame still follows
    ctx = "R8";
    rx = 1'b0;
    wait_cyc(3);
    rx = 1'b1;
    wait_cyc(3 * CPB);
    press(1'b1);
    wait_idle();
    send_rx(8'h55, 1'b1); exp_hold = 8'h55;
    press(1'b1);
    wait_idle();

    // R6: a press completing during a frame is ignored
    ctx = "R6";
    press(1'b1);
    press(1'b0);
    wait_idle();
    wait_cyc(300);
    chk_int("R6", frames, exp_frames);

    // R7: short pulse ignored, bounce then settle gives one frame
    ctx = "R7";
    btn = 1'b1;
    wait_cyc(10);
    btn = 1'b0;
    wait_cyc(4 * DEB);
    chk_int("R7", frames, exp_frames);
    for (int i = 0; i < 6; i++) begin
      btn = ~btn;
      wait_cyc(5);
    end
    press(1'b1);
    wait_idle();
    wait_cyc(200);
    chk_int("R7", frames, exp_frames);

    // R5 / R9: back-to-back presses each give one complete frame
    ctx = "R5";
    press(1'b1);
    wait_idle();
    press(1'b1);
    wait_idle();
    wait_cyc(100);
    chk_int("R5", frames, exp_frames);
    chk_int("R9", exp_q.size(), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run actual hung expected complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule